// File: doc/BRIEF.md
# Vector Indexed Address Generator

This block turns a gather-style memory operand into a stream of linear addresses, one for each element of a vector of indices. The operand is described by an addressing byte. Its top two bits give a scale. Its middle three bits name the vector register that holds the indices. Its low three bits name the general-purpose base register. Two extension bits widen both register numbers to four bits in 64-bit mode. The block also receives the processor mode, an address-size override flag and a flag telling whether the instruction carried the vector-extension prefix. From these it decides whether the encoding is legal and which effective address size applies.

The register numbers are decoded combinationally from the current inputs, so the register file can supply the base value and the index vector. A one-cycle start pulse then captures the base, a 32-bit displacement and the packed index vector. Every element address is base + (sign-extended index << scale) + sign-extended displacement. The addresses are emitted in ascending element order on a valid/ready output, and a done pulse follows the last one. An illegal encoding produces a fault pulse and no addresses. The index element width (32 or 64 bits) and the element count are parameters.

Top module: `vsib_agen`

## Requirements
- R1: The scale field, addressing byte bits 7:6, multiplies each sign-extended index by 1, 2, 4 or 8 (values 0, 1, 2, 3).
- R2: In 64-bit mode, indexReg = {extX, byte[5:3]} and baseReg = {extB, byte[2:0]}. Both are combinational from the current inputs.
- R3: Outside 64-bit mode the extension bits have no effect, and bit 3 of indexReg and of baseReg is 0.
- R4: With a 64-bit effective address size, each address is (baseVal + (sext(index) << scale) + sext(dispVal)) mod 2^64.
- R5: With a 32-bit effective address size, the same sum is truncated to 32 bits and zero-extended to 64 bits.
- R6: cpuMode encodes 00 as 16-bit, 01 as 32-bit and 10 as 64-bit; 11 is reserved and always faults. The override changes the effective address size as follows: 16-bit mode goes to 32, 32-bit mode goes to 16, and 64-bit mode goes to 32.
- R7: A 16-bit effective address size faults. This covers 16-bit mode without the override and 32-bit mode with the override. 16-bit mode with the override is legal.
- R8: A request without the vector-extension prefix faults, whatever the mode.
- R9: For a faulted request, fault is high for exactly the one cycle after the start edge, and outValid stays low.
- R10: For a legal request, outValid rises in the cycle after the start edge. Elements 0 to NUM_ELEM-1 follow in ascending order, and one is accepted in each cycle where outReady is high. After reset, outValid, fault and done are low.
- R11: While outValid is high and outReady is low, outAddr and outElem hold their values.
- R12: done is high for one cycle, the cycle after the last element is accepted, and is low otherwise. A start in that cycle is accepted. A start while addresses are still pending is ignored and changes no emitted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request pulse |
| sibByte | input | 8 | Addressing byte: scale, index register, base register |
| extB | input | 1 | Base register extension bit |
| extX | input | 1 | Index register extension bit |
| cpuMode | input | 2 | Processor mode: 00 16-bit, 01 32-bit, 10 64-bit, 11 reserved |
| asOverride | input | 1 | Address-size override present |
| vexPrefix | input | 1 | Instruction carries the vector-extension prefix |
| baseVal | input | 64 | Base register value |
| dispVal | input | 32 | Displacement, sign-extended internally |
| idxVec | input | NUM_ELEM*IDX_W | Packed index elements, element 0 in the low bits |
| baseReg | output | 4 | Decoded base register number |
| indexReg | output | 4 | Decoded vector index register number |
| outValid | output | 1 | Element address valid |
| outReady | input | 1 | Consumer accepts the element address |
| outAddr | output | 64 | Element linear address |
| outElem | output | max(1,$clog2(NUM_ELEM)) | Number of the element on outAddr |
| fault | output | 1 | Illegal encoding pulse |
| done | output | 1 | Pulse after the last element is accepted |

## Verification
Two events can fall in the same cycle. The done pulse of one request can coincide with the start of the next, and a stray start can arrive while a burst is still stalled or streaming. The bench issues every request at the moment the previous one finishes, so each start lands in the done cycle (or the fault-clear cycle) of its predecessor. In one request it also raises start mid-burst with a corrupted addressing byte. The new request is judged accepted if its first address appears in the very next cycle. The stray start is judged ignored if every later address of the running burst still matches the value computed from the operands captured at its own start.

// File: rtl/vsib_pkg.sv
package vsib_pkg;
  localparam int ADDR_W = 64;
  localparam int DISP_W = 32;

  typedef enum logic [1:0] {
    MODE_16  = 2'b00,
    MODE_32  = 2'b01,
    MODE_64  = 2'b10,
    MODE_RSV = 2'b11
  } cpuMode_e;

  typedef enum logic [1:0] {
    ASZ_16,
    ASZ_32,
    ASZ_64,
    ASZ_BAD
  } addrSize_e;

  typedef struct packed {
    logic load;
    logic step;
  } dpCtl_t;
endpackage

// File: rtl/vsib_ctrl.sv
module vsib_ctrl
  import vsib_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] cpuMode,
  input  logic       asOverride,
  input  logic       vexPrefix,
  input  logic       extB,
  input  logic       extX,
  input  logic [2:0] sibIdx,
  input  logic [2:0] sibBase,
  input  logic       outReady,
  input  logic       lastElem,
  output dpCtl_t     ctl,
  output logic       size32Now,
  output logic [3:0] baseReg,
  output logic [3:0] indexReg,
  output logic       outValid,
  output logic       fault,
  output logic       done
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_e;

  state_e    state;
  addrSize_e addrSz;
  cpuMode_e  mode;
  logic      legal;
  logic      accept;
  logic      is64;

  assign mode = cpuMode_e'(cpuMode);

  always_comb begin
    case (mode)
      MODE_16: addrSz = asOverride ? ASZ_32 : ASZ_16;
      MODE_32: addrSz = asOverride ? ASZ_16 : ASZ_32;
      MODE_64: addrSz = asOverride ? ASZ_32 : ASZ_64;
      default: addrSz = ASZ_BAD;
    endcase
  end

  assign legal     = vexPrefix && (addrSz == ASZ_32 || addrSz == ASZ_64);
  assign size32Now = (addrSz == ASZ_32);
  assign is64      = (mode == MODE_64);
  assign baseReg   = {is64 & extB, sibBase};
  assign indexReg  = {is64 & extX, sibIdx};

  assign outValid = (state == ST_BUSY);
  assign accept   = start && (state == ST_IDLE);
  assign ctl.load = accept && legal;
  assign ctl.step = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      fault <= 1'b0;
      done  <= 1'b0;
    end else begin
      fault <= accept && !legal;
      done  <= ctl.step && lastElem;
      if (ctl.load) state <= ST_BUSY;
      else if (ctl.step && lastElem) state <= ST_IDLE;
    end
  end

  // R9: a fault never comes with an address
  a_r9_fault_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !outValid);
  // R9: a fault is the answer to a start one cycle earlier
  a_r9_fault_after_start: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> $past(start));
  // R9: a fault lasts a single cycle unless a new faulting start came
  a_r9_fault_pulse: assert property (@(posedge clk) disable iff (!rstN)
    fault && !start |=> !fault);
  // R12: done comes only after an accepted element
  a_r12_done_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(outValid && outReady));
  // R3: extension bits are masked outside 64-bit mode
  a_r3_ext_masked: assert property (@(posedge clk) disable iff (!rstN)
    (cpuMode != 2'b10) |-> (!baseReg[3] && !indexReg[3]));
endmodule

// File: rtl/vsib_dp.sv
module vsib_dp
  import vsib_pkg::*;
#(
  parameter int NUM_ELEM = 4,
  parameter int IDX_W    = 32,
  localparam int ELEM_W  = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    ctl,
  input  logic                      size32Now,
  input  logic [1:0]                scaleIn,
  input  logic [ADDR_W-1:0]         baseVal,
  input  logic [DISP_W-1:0]         dispVal,
  input  logic [NUM_ELEM*IDX_W-1:0] idxVec,
  output logic                      lastElem,
  output logic [ADDR_W-1:0]         outAddr,
  output logic [ELEM_W-1:0]         outElem
);
  logic [1:0]                scaleQ;
  logic [ADDR_W-1:0]         baseQ;
  logic [DISP_W-1:0]         dispQ;
  logic [NUM_ELEM*IDX_W-1:0] idxQ;
  logic                      is32Q;
  logic [ELEM_W-1:0]         elemQ;
  logic [IDX_W-1:0]          idxArr [NUM_ELEM];
  logic [IDX_W-1:0]          idxSel;
  logic [ADDR_W-1:0]         idxExt;
  logic [ADDR_W-1:0]         dispExt;
  logic [ADDR_W-1:0]         sum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scaleQ <= '0;
      baseQ  <= '0;
      dispQ  <= '0;
      idxQ   <= '0;
      is32Q  <= 1'b0;
      elemQ  <= '0;
    end else if (ctl.load) begin
      scaleQ <= scaleIn;
      baseQ  <= baseVal;
      dispQ  <= dispVal;
      idxQ   <= idxVec;
      is32Q  <= size32Now;
      elemQ  <= '0;
    end else if (ctl.step) begin
      elemQ  <= elemQ + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_ELEM; g++) begin : gSlice
    assign idxArr[g] = idxQ[g*IDX_W +: IDX_W];
  end

  assign idxSel = idxArr[elemQ];

  if (IDX_W < ADDR_W) begin : gSext
    assign idxExt = {{(ADDR_W-IDX_W){idxSel[IDX_W-1]}}, idxSel};
  end else begin : gFull
    assign idxExt = idxSel[ADDR_W-1:0];
  end

  assign dispExt  = {{(ADDR_W-DISP_W){dispQ[DISP_W-1]}}, dispQ};
  assign sum      = baseQ + (idxExt << scaleQ) + dispExt;
  assign outAddr  = is32Q ? {{(ADDR_W-32){1'b0}}, sum[31:0]} : sum;
  assign outElem  = elemQ;
  assign lastElem = (elemQ == ELEM_W'(NUM_ELEM-1));

  // R5: a 32-bit request never shows upper address bits
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    is32Q |-> (outAddr[ADDR_W-1:32] == '0));
  // R10: element number moves up by one per accepted element
  a_r10_ascending: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step && !lastElem && !ctl.load |=> outElem == $past(outElem) + 1'b1);
endmodule

// File: rtl/vsib_agen.sv
module vsib_agen
  import vsib_pkg::*;
#(
  parameter int NUM_ELEM = 4,
  parameter int IDX_W    = 32,
  localparam int ELEM_W  = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [7:0]                sibByte,
  input  logic                      extB,
  input  logic                      extX,
  input  logic [1:0]                cpuMode,
  input  logic                      asOverride,
  input  logic                      vexPrefix,
  input  logic [63:0]               baseVal,
  input  logic [31:0]               dispVal,
  input  logic [NUM_ELEM*IDX_W-1:0] idxVec,
  output logic [3:0]                baseReg,
  output logic [3:0]                indexReg,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [63:0]               outAddr,
  output logic [ELEM_W-1:0]         outElem,
  output logic                      fault,
  output logic                      done
);
  dpCtl_t ctl;
  logic   size32Now;
  logic   lastElem;

  vsib_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .cpuMode   (cpuMode),
    .asOverride(asOverride),
    .vexPrefix (vexPrefix),
    .extB      (extB),
    .extX      (extX),
    .sibIdx    (sibByte[5:3]),
    .sibBase   (sibByte[2:0]),
    .outReady  (outReady),
    .lastElem  (lastElem),
    .ctl       (ctl),
    .size32Now (size32Now),
    .baseReg   (baseReg),
    .indexReg  (indexReg),
    .outValid  (outValid),
    .fault     (fault),
    .done      (done)
  );

  vsib_dp #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .size32Now(size32Now),
    .scaleIn  (sibByte[7:6]),
    .baseVal  (baseVal),
    .dispVal  (dispVal),
    .idxVec   (idxVec),
    .lastElem (lastElem),
    .outAddr  (outAddr),
    .outElem  (outElem)
  );

  // R11: a stalled element holds address and number
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outElem));
  // R12: done follows acceptance of the last element
  a_r12_done_last: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && (outElem == ELEM_W'(NUM_ELEM-1)) |=> done && !outValid);
endmodule

// File: tb/sim_vsib_agen.sv
module sim_vsib_agen;
  localparam int NUM_ELEM = 4;
  localparam int IDX_W    = 32;
  localparam int ELEM_W   = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic                      start = 1'b0;
  logic [7:0]                sibByte = '0;
  logic                      extB = 1'b0, extX = 1'b0;
  logic [1:0]                cpuMode = '0;
  logic                      asOverride = 1'b0, vexPrefix = 1'b0;
  logic [63:0]               baseVal = '0;
  logic [31:0]               dispVal = '0;
  logic [NUM_ELEM*IDX_W-1:0] idxVec = '0;
  logic [3:0]                baseReg, indexReg;
  logic                      outValid, fault, done;
  logic                      outReady = 1'b0;
  logic [63:0]               outAddr;
  logic [ELEM_W-1:0]         outElem;

  int checks = 0;
  int failures = 0;
  logic [IDX_W-1:0] idxE [NUM_ELEM];

  always #2.5 clk = ~clk;

  vsib_agen #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit legalOf(input logic [1:0] m, input logic ov, input logic vx);
    if (!vx || m == 2'b11) return 1'b0;
    if (m == 2'b00) return ov;
    if (m == 2'b01) return !ov;
    return 1'b1;
  endfunction

  function automatic bit is32Of(input logic [1:0] m, input logic ov);
    return (m == 2'b00 && ov) || (m == 2'b01 && !ov) || (m == 2'b10 && ov);
  endfunction

  function automatic logic [63:0] addrOf(input logic [63:0] b, input logic [IDX_W-1:0] ix,
                                         input logic [1:0] sc, input logic [31:0] d, input bit s32);
    logic [63:0] x, dx, mult, r;
    x = '0;
    for (int i = 0; i < 64; i++) x[i] = (i < IDX_W) ? ix[i] : ix[IDX_W-1];
    dx = {{32{d[31]}}, d};
    mult = 64'd1;
    for (int i = 0; i < int'(sc); i++) mult = mult * 64'd2;
    r = b + x * mult + dx;
    if (s32) r = {32'h0, r[31:0]};
    return r;
  endfunction

  // Caller stands at a negedge; returns at the negedge of the done or fault-clear cycle.
  task automatic runReq(input logic [7:0] s, input logic eb, input logic ex, input logic [1:0] m,
                        input logic ov, input logic vx, input logic [63:0] b, input logic [31:0] d,
                        input bit midStart);
    logic [63:0] expA [NUM_ELEM];
    bit lg, s32, rdy, stalled, didMid;
    int e;
    lg  = legalOf(m, ov, vx);
    s32 = is32Of(m, ov);
    for (int i = 0; i < NUM_ELEM; i++) expA[i] = addrOf(b, idxE[i], s[7:6], d, s32);
    sibByte = s; extB = eb; extX = ex; cpuMode = m; asOverride = ov; vexPrefix = vx;
    baseVal = b; dispVal = d;
    for (int i = 0; i < NUM_ELEM; i++) idxVec[i*IDX_W +: IDX_W] = idxE[i];
    start = 1'b1;
    #1;
    if (m == 2'b10) begin
      chk(baseReg == {eb, s[2:0]}, "R2 baseReg", 64'(baseReg), 64'({eb, s[2:0]}));
      chk(indexReg == {ex, s[5:3]}, "R2 indexReg", 64'(indexReg), 64'({ex, s[5:3]}));
    end else begin
      chk(baseReg == {1'b0, s[2:0]}, "R3 baseReg", 64'(baseReg), 64'({1'b0, s[2:0]}));
      chk(indexReg == {1'b0, s[5:3]}, "R3 indexReg", 64'(indexReg), 64'({1'b0, s[5:3]}));
    end
    @(negedge clk);
    start = 1'b0;
    if (!lg) begin
      chk(fault == 1'b1, (vx ? "R7 fault" : "R8 fault"), 64'(fault), 64'd1);
      chk(outValid == 1'b0, "R9 no valid on fault", 64'(outValid), 64'd0);
      @(negedge clk);
      chk(fault == 1'b0, "R9 fault one cycle", 64'(fault), 64'd0);
      chk(outValid == 1'b0, "R9 still no valid", 64'(outValid), 64'd0);
      return;
    end
    chk(fault == 1'b0, "R6 legal no fault", 64'(fault), 64'd0);
    e = 0; stalled = 0; didMid = 0;
    while (e < NUM_ELEM) begin
      chk(outValid == 1'b1, "R10 valid", 64'(outValid), 64'd1);
      chk(outElem == ELEM_W'(e), "R10 order", 64'(outElem), 64'(e));
      chk(outAddr == expA[e], (stalled ? "R11 hold" : (s32 ? "R5 addr32" : "R4 addr64")),
          outAddr, expA[e]);
      chk(done == 1'b0, "R12 no early done", 64'(done), 64'd0);
      if (midStart && e == 1 && !didMid) begin
        start = 1'b1; sibByte = ~s; baseVal = ~b; didMid = 1;
      end else start = 1'b0;
      rdy = ($urandom % 3) != 0;
      outReady = rdy;
      @(negedge clk);
      stalled = !rdy;
      if (rdy) e++;
    end
    start = 1'b0;
    outReady = 1'b0;
    chk(done == 1'b1, "R12 done", 64'(done), 64'd1);
    chk(outValid == 1'b0, "R12 idle after done", 64'(outValid), 64'd0);
  endtask

  task automatic randIdx();
    logic [63:0] r;
    for (int i = 0; i < NUM_ELEM; i++) begin
      r = {$urandom, $urandom};
      idxE[i] = r[IDX_W-1:0];
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NUM_ELEM; i++) idxE[i] = IDX_W'(i + 1);
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0 && fault == 1'b0 && done == 1'b0, "R10 reset state",
        {61'd0, outValid, fault, done}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: each scale value, 64-bit addressing
    for (int sc = 0; sc < 4; sc++)
      runReq({2'(sc), 3'd2, 3'd5}, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 64'h1000_0000_0000, 32'h10, 1'b0);
    // R4: negative indices and negative displacement wrap
    for (int i = 0; i < NUM_ELEM; i++) idxE[i] = '1 - IDX_W'(i);
    runReq(8'hC7, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 64'h20, 32'hFFFF_FF00, 1'b0);
    // R5: 64-bit mode with override gives 32-bit addresses
    runReq(8'h4B, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 64'hDEAD_BEEF_FFFF_FFF0, 32'h40, 1'b0);
    // R3: 32-bit mode with extension bits set
    randIdx();
    runReq(8'h9E, 1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, 32'h8, 1'b0);
    // R7: 16-bit mode with override is legal
    runReq(8'h11, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 64'h7FFF_FFF0, 32'h100, 1'b0);
    // R7: 32-bit mode with override faults; 16-bit mode without override faults
    runReq(8'h00, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 64'h0, 32'h0, 1'b0);
    runReq(8'h00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 64'h0, 32'h0, 1'b0);
    // R8: missing prefix faults in 64-bit mode
    runReq(8'h5A, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 64'h1234, 32'h0, 1'b0);
    // R6: reserved mode faults
    runReq(8'h5A, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 64'h1234, 32'h0, 1'b0);
    // R12: stray start mid-burst is ignored
    randIdx();
    runReq(8'h63, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 64'hFEDC_BA98_7654_3210, 32'h8000_0000, 1'b1);
    // random mix, each request issued in the done cycle of the previous
    for (int n = 0; n < 60; n++) begin
      randIdx();
      runReq(8'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
             (($urandom % 8) != 0), {$urandom, $urandom}, $urandom, (($urandom % 5) == 0));
    end
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule